// File: doc/BRIEF.md
# Software Interrupt Admission Filter

This block sits in front of the pending state of the sixteen software-generated interrupts owned by one processor. Each incoming request names a target interrupt, the group the sender is asking for (secure group 0 or secure group 1), and whether the sender runs in the non-secure world. The filter works out the effective group of every interrupt from its configuration, checks the request against group-matching and non-secure access rules, and either raises a one-cycle pending-set strobe for that interrupt or silently drops the request.

The per-interrupt configuration (group bit, group-modifier bit and a 2-bit non-secure access level) and a global security-disable input come in as flat vectors. The effective group of every interrupt is also driven out so that neighbouring logic can use it. Requests use a valid/ready handshake with one request accepted per cycle. The decision is registered, so each admitted request also pulses a rescan signal that tells the priority logic to look again for the highest-priority pending interrupt.

Top module: `sgi_admit_filter`

## Requirements
- R1: With security_off high, every interrupt resolves from its group bit alone: 0 gives group 0 and 1 gives non-secure group 1. Group codes on grp_resolved are 2 bits per interrupt, interrupt i at bits [2i+1:2i]: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1.
- R2: With security_off low, the (modifier, group) pair resolves as 00 to group 0, 01 to non-secure group 1 and 10 to secure group 1.
- R3: With security_off low, the pair (modifier 1, group 1) resolves to secure group 1.
- R4: A request asking for secure group 1 (req_want_g1s high) whose target resolves to group 0 is dropped; one whose target resolves to either group 1 passes this rule.
- R5: A request asking for group 0 (req_want_g1s low) whose target does not resolve to group 0 is dropped.
- R6: With security_off low and req_from_ns high, a request is dropped when its target is group 0 with access level 0, or secure group 1 with access level 0 or 1; cfg_ns_level holds interrupt i at bits [2i+1:2i].
- R7: An admitted request sets exactly bit req_id of pend_set and raises rescan_pulse, both for one cycle, on the clock edge after the one that accepted it; a dropped request leaves both low.
- R8: req_ready is high from the first clock edge after reset release onward, so requests are accepted back to back, one per cycle; with no accepted request pend_set and rescan_pulse stay low.
- R9: During reset req_ready, pend_set and rescan_pulse are all low.
- R10: With security_off high, req_from_ns and the access levels have no effect on admission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| security_off | input | 1 | Global security-disable |
| cfg_group | input | NUM_IDS | Group bit per interrupt |
| cfg_modifier | input | NUM_IDS | Group-modifier bit per interrupt |
| cfg_ns_level | input | NUM_IDS*LVL_W | Non-secure access level per interrupt |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_id | input | ID_W | Target interrupt number |
| req_want_g1s | input | 1 | Requested group: 1 secure group 1, 0 group 0 |
| req_from_ns | input | 1 | Request comes from the non-secure world |
| pend_set | output | NUM_IDS | One-hot pending-set strobe |
| rescan_pulse | output | 1 | Re-evaluate highest-priority pending interrupt |
| grp_resolved | output | NUM_IDS*2 | Effective group of every interrupt |

## Verification
The bench chases the asymmetric group match: a secure-group-1 request aimed at a non-secure group 1 interrupt must pass, and a design that demanded an exact match would drop it and leave pend_set low. It drives non-secure requests at levels 0, 1 and 2 for both secure groups, where an off-by-one threshold shows up as a wrongly admitted or dropped strobe, and repeats them with security disabled to catch a design that still applies the access levels. The (1,1) encoding and the security-disabled resolution are swept across all interrupts, and back-to-back requests check that every strobe lands exactly one edge after its acceptance and never merges with its neighbour.

// File: rtl/sgaf_pkg.sv
package sgaf_pkg;

   typedef enum logic [1:0] {
      GRP_0   = 2'd0,
      GRP_1S  = 2'd1,
      GRP_1NS = 2'd2
   } grp_e;

   localparam int GRP_W = 2;

   // Effective group of one interrupt.
   function automatic grp_e grp_of(input logic sec_off,
                                   input logic modifier,
                                   input logic group_bit);
      grp_e g;
      if (sec_off) begin
         g = group_bit ? GRP_1NS : GRP_0;
      end else begin
         unique case ({modifier, group_bit})
            2'b00:   g = GRP_0;
            2'b01:   g = GRP_1NS;
            default: g = GRP_1S;
         endcase
      end
      return g;
   endfunction

endpackage

// File: rtl/sgaf_group_resolve.sv
module sgaf_group_resolve
   import sgaf_pkg::*;
#(
   parameter int NUM_IDS      = 16,
   parameter bit REG_RESOLVED = 1'b0,
   localparam int VEC_W       = NUM_IDS * GRP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_off,
   input  logic [NUM_IDS-1:0] cfg_group,
   input  logic [NUM_IDS-1:0] cfg_modifier,
   output logic [VEC_W-1:0]   grp_now,
   output logic [VEC_W-1:0]   grp_out
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IDS; gi++) begin : g_id
         assign grp_now[gi*GRP_W +: GRP_W] =
            grp_of(sec_off, cfg_modifier[gi], cfg_group[gi]);
      end

      if (REG_RESOLVED) begin : g_reg
         logic [VEC_W-1:0] grp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) grp_q <= '0;
            else        grp_q <= grp_now;
         end
         assign grp_out = grp_q;
      end else begin : g_comb
         assign grp_out = grp_now;
      end

      // With security disabled no interrupt may be secure group 1.
      for (gi = 0; gi < NUM_IDS; gi++) begin : g_chk
         p_no_g1s_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
            sec_off |-> (grp_now[gi*GRP_W +: GRP_W] != GRP_1S));
         p_both_set_is_g1s_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sec_off && cfg_modifier[gi] && cfg_group[gi])
               |-> (grp_now[gi*GRP_W +: GRP_W] == GRP_1S));
      end
   endgenerate

endmodule

// File: rtl/sgaf_admit_check.sv
module sgaf_admit_check
   import sgaf_pkg::*;
#(
   parameter int NUM_IDS = 16,
   parameter int LVL_W   = 2,
   localparam int ID_W   = $clog2(NUM_IDS),
   localparam int VEC_W  = NUM_IDS * GRP_W
) (
   input  logic                     sec_off,
   input  logic [VEC_W-1:0]         grp_all,
   input  logic [NUM_IDS*LVL_W-1:0] lvl_all,
   input  logic [ID_W-1:0]          id,
   input  logic                     want_g1s,
   input  logic                     from_ns,
   output grp_e                     tgt_grp,
   output logic                     admit
);

   logic [LVL_W-1:0] tgt_lvl;
   logic             id_ok;
   logic             grp_match;
   logic             ns_block;

   always_comb begin
      tgt_grp = GRP_0;
      tgt_lvl = '0;
      for (int i = 0; i < NUM_IDS; i++) begin
         if (id == ID_W'(i)) begin
            tgt_grp = grp_e'(grp_all[i*GRP_W +: GRP_W]);
            tgt_lvl = lvl_all[i*LVL_W +: LVL_W];
         end
      end
   end

   generate
      if (NUM_IDS == (1 << ID_W)) begin : g_full_range
         assign id_ok = 1'b1;
      end else begin : g_part_range
         assign id_ok = (32'(id) < NUM_IDS);
      end
   endgenerate

   always_comb begin
      if (want_g1s) grp_match = (tgt_grp != GRP_0);
      else          grp_match = (tgt_grp == GRP_0);
   end

   always_comb begin
      ns_block = 1'b0;
      if (from_ns && !sec_off) begin
         if (tgt_grp == GRP_0  && tgt_lvl < LVL_W'(1)) ns_block = 1'b1;
         if (tgt_grp == GRP_1S && tgt_lvl < LVL_W'(2)) ns_block = 1'b1;
      end
   end

   assign admit = id_ok && grp_match && !ns_block;

endmodule

// File: rtl/sgi_admit_filter.sv
module sgi_admit_filter
   import sgaf_pkg::*;
#(
   parameter int NUM_IDS      = 16,
   parameter int LVL_W        = 2,
   parameter bit REG_RESOLVED = 1'b0,
   localparam int ID_W        = $clog2(NUM_IDS),
   localparam int VEC_W       = NUM_IDS * GRP_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     security_off,
   input  logic [NUM_IDS-1:0]       cfg_group,
   input  logic [NUM_IDS-1:0]       cfg_modifier,
   input  logic [NUM_IDS*LVL_W-1:0] cfg_ns_level,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ID_W-1:0]          req_id,
   input  logic                     req_want_g1s,
   input  logic                     req_from_ns,
   output logic [NUM_IDS-1:0]       pend_set,
   output logic                     rescan_pulse,
   output logic [VEC_W-1:0]         grp_resolved
);

   generate
      if (NUM_IDS < 2) begin : g_bad_ids
         $error("sgi_admit_filter: NUM_IDS must be at least 2");
      end
      if (LVL_W < 2) begin : g_bad_lvl
         $error("sgi_admit_filter: LVL_W must hold the value 2");
      end
   endgenerate

   logic [VEC_W-1:0]   grp_now;
   grp_e               tgt_grp;
   logic               admit;
   logic               fire;
   logic               ready_q;
   logic [NUM_IDS-1:0] pend_q;
   logic               rescan_q;
   logic [LVL_W-1:0]   tgt_lvl_chk;

   sgaf_group_resolve #(
      .NUM_IDS      (NUM_IDS),
      .REG_RESOLVED (REG_RESOLVED)
   ) u_resolve (
      .clk          (clk),
      .rst_n        (rst_n),
      .sec_off      (security_off),
      .cfg_group    (cfg_group),
      .cfg_modifier (cfg_modifier),
      .grp_now      (grp_now),
      .grp_out      (grp_resolved)
   );

   sgaf_admit_check #(
      .NUM_IDS  (NUM_IDS),
      .LVL_W    (LVL_W)
   ) u_admit (
      .sec_off  (security_off),
      .grp_all  (grp_now),
      .lvl_all  (cfg_ns_level),
      .id       (req_id),
      .want_g1s (req_want_g1s),
      .from_ns  (req_from_ns),
      .tgt_grp  (tgt_grp),
      .admit    (admit)
   );

   assign fire = req_valid && ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         pend_q   <= '0;
         rescan_q <= 1'b0;
      end else begin
         ready_q  <= 1'b1;
         rescan_q <= fire && admit;
         if (fire && admit) pend_q <= NUM_IDS'(1) << req_id;
         else               pend_q <= '0;
      end
   end

   assign req_ready    = ready_q;
   assign pend_set     = pend_q;
   assign rescan_pulse = rescan_q;

   // Level of the requested interrupt, picked independently for checking.
   assign tgt_lvl_chk = cfg_ns_level[req_id*LVL_W +: LVL_W];

   p_onehot_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_set));
   p_rescan_with_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rescan_pulse == (pend_set != '0));
   p_g1s_to_g0_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_want_g1s && tgt_grp == GRP_0) |=> (pend_set == '0));
   p_g0_mismatch_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_want_g1s && tgt_grp != GRP_0) |=> (pend_set == '0));
   p_ns_level_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_from_ns && !security_off && tgt_grp == GRP_1S &&
       tgt_lvl_chk < LVL_W'(2)) |=> (pend_set == '0));
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> (pend_set == '0 && !rescan_pulse));
   p_ready_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> req_ready);

endmodule

// File: tb/sgi_admit_filter_tb_top.sv
module sgi_admit_filter_tb_top;

   localparam int N  = 16;
   localparam int IW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            security_off = 1'b0;
   logic [N-1:0]    cfg_group = '0;
   logic [N-1:0]    cfg_modifier = '0;
   logic [2*N-1:0]  cfg_ns_level = '0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [IW-1:0]   req_id = '0;
   logic            req_want_g1s = 1'b0;
   logic            req_from_ns = 1'b0;
   logic [N-1:0]    pend_set;
   logic            rescan_pulse;
   logic [2*N-1:0]  grp_resolved;

   int n_checks = 0;
   int n_fail   = 0;

   logic         m_ready = 1'b0;
   logic [N-1:0] m_pend  = '0;
   string        m_tag   = "R9";

   always #5 clk = ~clk;

   sgi_admit_filter dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .security_off (security_off),
      .cfg_group    (cfg_group),
      .cfg_modifier (cfg_modifier),
      .cfg_ns_level (cfg_ns_level),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_id       (req_id),
      .req_want_g1s (req_want_g1s),
      .req_from_ns  (req_from_ns),
      .pend_set     (pend_set),
      .rescan_pulse (rescan_pulse),
      .grp_resolved (grp_resolved)
   );

   // Reference: 0 group 0, 1 secure group 1, 2 non-secure group 1.
   function automatic int ref_grp(int i);
      if (security_off) return cfg_group[i] ? 2 : 0;
      if (!cfg_modifier[i]) return cfg_group[i] ? 2 : 0;
      return 1;
   endfunction

   function automatic string grp_tag(int i);
      if (security_off) return "R1";
      if (cfg_modifier[i] && cfg_group[i]) return "R3";
      return "R2";
   endfunction

   // Returns 1 when admitted; tag names the deciding rule.
   function automatic bit ref_admit(output string tag);
      int g;
      int lvl;
      g   = ref_grp(int'(req_id));
      lvl = int'(cfg_ns_level[2*req_id +: 2]);
      if (req_want_g1s && g == 0) begin tag = "R4"; return 0; end
      if (!req_want_g1s && g != 0) begin tag = "R5"; return 0; end
      if (req_from_ns && security_off) begin tag = "R10"; return 1; end
      if (req_from_ns) begin
         if (g == 0 && lvl < 1) begin tag = "R6"; return 0; end
         if (g == 1 && lvl < 2) begin tag = "R6"; return 0; end
         tag = "R6";
         return 1;
      end
      tag = "R7";
      return 1;
   endfunction

   task automatic check_now();
      n_checks++;
      if (pend_set !== m_pend) begin
         n_fail++;
         $display("FAIL %s pend_set actual=%h expected=%h", m_tag, pend_set, m_pend);
      end
      n_checks++;
      if (rescan_pulse !== (m_pend != '0)) begin
         n_fail++;
         $display("FAIL R7 rescan_pulse actual=%b expected=%b", rescan_pulse, (m_pend != '0));
      end
      n_checks++;
      if (req_ready !== m_ready) begin
         n_fail++;
         $display("FAIL %s req_ready actual=%b expected=%b",
                  rst_n ? "R8" : "R9", req_ready, m_ready);
      end
      for (int i = 0; i < N; i++) begin
         n_checks++;
         if (int'(grp_resolved[2*i +: 2]) != ref_grp(i)) begin
            n_fail++;
            $display("FAIL %s grp[%0d] actual=%0d expected=%0d",
                     grp_tag(i), i, grp_resolved[2*i +: 2], ref_grp(i));
         end
      end
   endtask

   // Inputs are set at a falling edge; predict the next rising edge, then
   // compare at the falling edge after it.
   task automatic step();
      string tag;
      bit    ok;
      bit    fire;
      fire = rst_n && req_valid && m_ready;
      ok   = ref_admit(tag);
      if (!rst_n) begin
         m_pend  = '0;
         m_ready = 1'b0;
         m_tag   = "R9";
      end else begin
         m_pend  = (fire && ok) ? (N'(1) << req_id) : '0;
         m_tag   = fire ? tag : "R8";
         m_ready = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      check_now();
   endtask

   task automatic req(int id, bit g1s, bit ns);
      req_valid    = 1'b1;
      req_id       = IW'(id);
      req_want_g1s = g1s;
      req_from_ns  = ns;
      step();
   endtask

   task automatic set_cfg(int id, bit m, bit g, int lvl);
      cfg_modifier[id]      = m;
      cfg_group[id]         = g;
      cfg_ns_level[2*id +: 2] = 2'(lvl);
   endtask

   initial begin : watchdog
      #1500000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      // R9: reset state, even with a request offered.
      req_valid = 1'b1;
      step();
      step();
      rst_n = 1'b1;
      req_valid = 1'b0;
      step();
      step();

      // R2 / R3: secure resolution on distinct ids.
      security_off = 1'b0;
      set_cfg(0, 0, 0, 0);
      set_cfg(1, 0, 1, 0);
      set_cfg(2, 1, 0, 0);
      set_cfg(3, 1, 1, 0);
      set_cfg(4, 1, 0, 1);
      set_cfg(5, 1, 0, 2);
      set_cfg(6, 0, 0, 1);
      step();
      // R4: g1s request to group 0 dropped; R4 to non-secure group 1 admitted.
      req(0, 1, 0);
      req(1, 1, 0);
      // R5: group 0 request to secure group 1 dropped; to group 0 admitted.
      req(2, 0, 0);
      req(0, 0, 0);
      // R3 target used as secure group 1, back to back (R8).
      req(3, 1, 0);
      req(3, 1, 0);
      // R6: non-secure levels.
      req(0, 0, 1);
      req(6, 0, 1);
      req(3, 1, 1);
      req(4, 1, 1);
      req(5, 1, 1);
      req(1, 1, 1);
      req_valid = 1'b0;
      step();

      // R1 / R10: security disabled.
      security_off = 1'b1;
      cfg_modifier = '1;
      cfg_group    = 16'hA5C3;
      cfg_ns_level = '0;
      step();
      req(0, 0, 1);
      req(1, 1, 1);
      req(2, 0, 1);
      req(0, 1, 1);
      req_valid = 1'b0;
      step();

      // Random traffic with periodic reconfiguration.
      for (int c = 0; c < 3000; c++) begin
         if (c % 40 == 0) begin
            security_off = ($urandom_range(0, 3) == 0);
            cfg_group    = N'($urandom);
            cfg_modifier = N'($urandom);
            cfg_ns_level = $urandom;
         end
         req_valid    = ($urandom_range(0, 9) < 7);
         req_id       = IW'($urandom);
         req_want_g1s = 1'($urandom);
         req_from_ns  = 1'($urandom);
         step();
      end

      // Mid-run reset returns to the reset state (R9).
      req_valid = 1'b1;
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      req_valid = 1'b0;
      step();

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule